// File: doc/BRIEF.md
# Per-Port Ethernet Statistics Counter Bank

This block keeps receive and transmit statistics for a set of Ethernet ports. Each port's MAC presents one receive strobe and one transmit strobe per clock. Each strobe carries the frame length, a two-bit frame class (unicast, broadcast, multicast or pause) and a set of error flags. The block turns every strobe into counter updates: class counters, frame-length buckets, error counters, and three byte counters that are 64 bits wide.

A host reads any counter as a 32-bit word through an address window. Each port has its own 256-byte window. A global enable register gates all counting. A control register starts a clear of every counter and shows a busy bit while the clear runs. The clear visits one counter word per clock, across all ports in order. The busy bit drops by itself once the last word has been cleared.

Top module: `stats_top`

## Requirements
- R1: After reset every counter word reads 0, the control register reads 0 (not busy) and the enable register reads 0.
- R2: A read of address A puts its data on rd_data_o in the cycle after rd_en_i. Port n's counters sit at 0x1000 + n*0x100 + 4*word for words 0..43. The enable register is at 0x0034 and the control register at 0x0030. Any other address, any misaligned address, a port number of NP or above, and the reserved words 42 and 43 all read 0.
- R3: The frame class codes are 1 for broadcast, 2 for multicast and 3 for pause; code 0 counts nothing. Receive frames count at words 0, 2 and 1 for these classes. Transmit frames count at words 21, 23 and 22.
- R4: A frame of 64 bytes or more increments exactly one length bucket. The buckets are 64 or less, 65-127, 128-255, 256-511, 512-1023, 1024-1518 and 1519 or more. They sit at receive words 7..13 and transmit words 25..31, in that order. Frames shorter than 64 bytes go to no bucket.
- R5: A receive frame shorter than 64 bytes counts as a runt (word 5) when its FCS flag (rx_err bit 0) is clear, and as a fragment (word 6) when the flag is set. The FCS error counter (word 3) counts only frames of 64 bytes or more that have the flag set.
- R6: The other receive error flags each increment their own counter. Bit 1 (alignment) goes to word 4, bit 2 (too long) to word 14, bit 3 (overflow) to word 19 and bit 4 (filtered) to word 20.
- R7: Each byte counter is 64 bits: the low half is at the word shown below and the high half is in the word above it. A receive frame of at least 64 bytes with none of rx_err bits 0..3 set adds its length to the good-byte counter (words 15/16). Any other receive frame adds its length to the bad-byte counter (words 17/18). Every transmit frame adds its length to words 33/34.
- R8: Each transmit flag increments its own counter. Bit 0 goes to word 24, bit 1 to 32, bit 2 to 35, bit 3 to 36, bit 4 to 37, bit 5 to 38, bit 6 to 39, bit 7 to 40 and bit 8 to 41.
- R9: Writing the enable register stores data bit 0. While that bit is 0, strobes change no counter.
- R10: A write to the control register with data bits 1 and 0 both set starts a clear. Control bit 0 then reads 1 for exactly NP*44 cycles and 0 afterwards, and every counter is 0 once the clear ends. A write with only bit 1 set starts nothing and changes no counter.
- R11: The clear handles word k of port p (k + 44*p) cycles after it starts. An increment aimed at the word being cleared in that same cycle is lost. Increments to words the clear has already passed are kept.
- R12: A start write that arrives while a clear is running is ignored and does not lengthen the busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_vld_i | input | NP | Receive strobe, one bit per port |
| rx_len_i | input | NP*LEN_W | Receive frame length in bytes, one field per port |
| rx_kind_i | input | NP*2 | Receive frame class per port |
| rx_err_i | input | NP*5 | Receive flags per port: FCS, alignment, too long, overflow, filtered |
| tx_vld_i | input | NP | Transmit strobe, one bit per port |
| tx_len_i | input | NP*LEN_W | Transmit frame length in bytes, one field per port |
| tx_kind_i | input | NP*2 | Transmit frame class per port |
| tx_err_i | input | NP*9 | Transmit flags per port |
| wr_en_i | input | 1 | Host register write strobe |
| wr_addr_i | input | 16 | Host write byte address |
| wr_data_i | input | 32 | Host write data |
| rd_en_i | input | 1 | Host read strobe |
| rd_addr_i | input | 16 | Host read byte address |
| rd_data_o | output | 32 | Read data, valid the cycle after rd_en_i |

## Verification
Some properties are checked on every cycle. The busy period of each clear is measured against NP*44 cycles. The clear must start after a valid command and only then. The enable bit must take the written value. Reads of unmapped addresses and of the control register must return the right data one cycle later. The bench's scenarios are the only proof of the counting itself: bucket edges at 63/64/65, 127/128, 1518/1519 and so on; runts and fragments; splitting bytes into good and bad; and the flag-to-counter mapping. They also show that enable gating works, that a start write during a clear is ignored, and that a same-cycle increment loses to the clear while increments to already-cleared words survive. A reference model in the bench checks each of these.

// File: rtl/stats_pkg.sv
package stats_pkg;
  localparam int CNT_WORDS = 44;

  typedef struct packed {
    logic        vld;
    logic [1:0]  kind;
    logic [4:0]  err;   // 0 fcs, 1 align, 2 too long, 3 overflow, 4 filtered
    logic [15:0] len;
  } rx_ev_t;

  typedef struct packed {
    logic        vld;
    logic [1:0]  kind;
    logic [8:0]  err;
    logic [15:0] len;
  } tx_ev_t;

  localparam logic [1:0] K_BC = 2'd1, K_MC = 2'd2, K_PAUSE = 2'd3;

  localparam int W_RX_BC = 0,  W_RX_PAUSE = 1, W_RX_MC = 2,   W_RX_FCS = 3;
  localparam int W_RX_ALIGN = 4, W_RX_RUNT = 5, W_RX_FRAG = 6, W_RX_B0 = 7;
  localparam int W_RX_LONG = 14, W_RX_GOOD = 15, W_RX_BAD = 17, W_RX_OVF = 19;
  localparam int W_RX_FILT = 20, W_TX_BC = 21, W_TX_PAUSE = 22, W_TX_MC = 23;
  localparam int W_TX_UNDER = 24, W_TX_B0 = 25, W_TX_OVSZ = 32, W_TX_BYTES = 33;
  localparam int W_TX_COL = 35;  // tx flags 2..8 map to words 35..41

  function automatic logic [2:0] len_bucket(input logic [15:0] l);
    if (l <= 16'd64)        return 3'd0;
    else if (l <= 16'd127)  return 3'd1;
    else if (l <= 16'd255)  return 3'd2;
    else if (l <= 16'd511)  return 3'd3;
    else if (l <= 16'd1023) return 3'd4;
    else if (l <= 16'd1518) return 3'd5;
    else                    return 3'd6;
  endfunction
endpackage

// File: rtl/stats_flush.sv
module stats_flush #(
  parameter int NP = 2,
  parameter int NW = 44,
  localparam int PW = (NP > 1) ? $clog2(NP) : 1,
  localparam int WW = $clog2(NW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic [PW-1:0] port_o,
  output logic [WW-1:0] word_o
);
  logic          busy_q;
  logic [PW-1:0] port_q;
  logic [WW-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      port_q <= '0;
      word_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        port_q <= '0;
        word_q <= '0;
      end
    end else if (int'(word_q) == NW - 1) begin
      word_q <= '0;
      if (int'(port_q) == NP - 1) busy_q <= 1'b0;
      else                        port_q <= port_q + 1'b1;
    end else begin
      word_q <= word_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign port_o = port_q;
  assign word_o = word_q;
endmodule

// File: rtl/stats_port.sv
module stats_port
  import stats_pkg::*;
#(
  parameter int NW = CNT_WORDS,
  localparam int WW = $clog2(NW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  rx_ev_t        rx_i,
  input  tx_ev_t        tx_i,
  input  logic          clr_i,
  input  logic [WW-1:0] clr_word_i,
  input  logic [WW-1:0] rd_word_i,
  output logic [31:0]   rd_data_o
);
  logic [31:0] cnt_q [NW];
  logic [31:0] nxt   [NW];
  logic [NW-1:0] we;
  logic [63:0] rxg_sum, rxb_sum, tx_sum;
  logic rx_go, tx_go, rx_big, tx_big, rx_good;

  assign rx_go   = en_i && rx_i.vld;
  assign tx_go   = en_i && tx_i.vld;
  assign rx_big  = rx_i.len >= 16'd64;
  assign tx_big  = tx_i.len >= 16'd64;
  assign rx_good = rx_big && (rx_i.err[3:0] == 4'd0);
  assign rxg_sum = {cnt_q[W_RX_GOOD+1], cnt_q[W_RX_GOOD]} + 64'(rx_i.len);
  assign rxb_sum = {cnt_q[W_RX_BAD+1],  cnt_q[W_RX_BAD]}  + 64'(rx_i.len);
  assign tx_sum  = {cnt_q[W_TX_BYTES+1], cnt_q[W_TX_BYTES]} + 64'(tx_i.len);

  always_comb begin
    we = '0;
    for (int w = 0; w < NW; w++) nxt[w] = cnt_q[w] + 32'd1;
    if (rx_go) begin
      case (rx_i.kind)
        K_BC:    we[W_RX_BC]    = 1'b1;
        K_MC:    we[W_RX_MC]    = 1'b1;
        K_PAUSE: we[W_RX_PAUSE] = 1'b1;
        default: ;
      endcase
      if (rx_big) begin
        we[W_RX_B0 + int'(len_bucket(rx_i.len))] = 1'b1;
        if (rx_i.err[0]) we[W_RX_FCS] = 1'b1;
      end else if (rx_i.err[0]) we[W_RX_FRAG] = 1'b1;
      else                      we[W_RX_RUNT] = 1'b1;
      if (rx_i.err[1]) we[W_RX_ALIGN] = 1'b1;
      if (rx_i.err[2]) we[W_RX_LONG]  = 1'b1;
      if (rx_i.err[3]) we[W_RX_OVF]   = 1'b1;
      if (rx_i.err[4]) we[W_RX_FILT]  = 1'b1;
      if (rx_good) begin
        we[W_RX_GOOD] = 1'b1; we[W_RX_GOOD+1] = 1'b1;
        nxt[W_RX_GOOD] = rxg_sum[31:0]; nxt[W_RX_GOOD+1] = rxg_sum[63:32];
      end else begin
        we[W_RX_BAD] = 1'b1; we[W_RX_BAD+1] = 1'b1;
        nxt[W_RX_BAD] = rxb_sum[31:0]; nxt[W_RX_BAD+1] = rxb_sum[63:32];
      end
    end
    if (tx_go) begin
      case (tx_i.kind)
        K_BC:    we[W_TX_BC]    = 1'b1;
        K_MC:    we[W_TX_MC]    = 1'b1;
        K_PAUSE: we[W_TX_PAUSE] = 1'b1;
        default: ;
      endcase
      if (tx_big) we[W_TX_B0 + int'(len_bucket(tx_i.len))] = 1'b1;
      if (tx_i.err[0]) we[W_TX_UNDER] = 1'b1;
      if (tx_i.err[1]) we[W_TX_OVSZ]  = 1'b1;
      for (int b = 2; b < 9; b++)
        if (tx_i.err[b]) we[W_TX_COL + b - 2] = 1'b1;
      we[W_TX_BYTES] = 1'b1; we[W_TX_BYTES+1] = 1'b1;
      nxt[W_TX_BYTES] = tx_sum[31:0]; nxt[W_TX_BYTES+1] = tx_sum[63:32];
    end
  end

  // clear beats a same-cycle increment on the same word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < NW; w++) cnt_q[w] <= '0;
    end else begin
      for (int w = 0; w < NW; w++) begin
        if (clr_i && int'(clr_word_i) == w) cnt_q[w] <= '0;
        else if (we[w])                     cnt_q[w] <= nxt[w];
      end
    end
  end

  assign rd_data_o = cnt_q[rd_word_i];
endmodule

// File: rtl/stats_top.sv
module stats_top
  import stats_pkg::*;
#(
  parameter int          NP        = 2,
  parameter int          LEN_W     = 14,
  parameter int          NW        = CNT_WORDS,
  parameter logic [15:0] CTRL_ADDR = 16'h0030,
  parameter logic [15:0] EN_ADDR   = 16'h0034,
  localparam int PW = (NP > 1) ? $clog2(NP) : 1,
  localparam int WW = $clog2(NW)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NP-1:0]       rx_vld_i,
  input  logic [NP*LEN_W-1:0] rx_len_i,
  input  logic [NP*2-1:0]     rx_kind_i,
  input  logic [NP*5-1:0]     rx_err_i,
  input  logic [NP-1:0]       tx_vld_i,
  input  logic [NP*LEN_W-1:0] tx_len_i,
  input  logic [NP*2-1:0]     tx_kind_i,
  input  logic [NP*9-1:0]     tx_err_i,
  input  logic                wr_en_i,
  input  logic [15:0]         wr_addr_i,
  input  logic [31:0]         wr_data_i,
  input  logic                rd_en_i,
  input  logic [15:0]         rd_addr_i,
  output logic [31:0]         rd_data_o
);
  logic          en_q, busy, start;
  logic [PW-1:0] fl_port;
  logic [WW-1:0] fl_word;
  logic [31:0]   port_rd [NP];
  logic [31:0]   rd_val, rd_data_q;
  logic [3:0]    rd_port;
  logic [5:0]    rd_word;
  logic          unused_wr_bits;

  assign unused_wr_bits = ^wr_data_i[31:2];
  assign start   = wr_en_i && (wr_addr_i == CTRL_ADDR) && (wr_data_i[1:0] == 2'b11);
  assign rd_port = rd_addr_i[11:8];
  assign rd_word = rd_addr_i[7:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else if (wr_en_i && wr_addr_i == EN_ADDR) en_q <= wr_data_i[0];
  end

  stats_flush #(.NP(NP), .NW(NW)) u_flush (
    .clk_i, .rst_ni, .start_i(start), .busy_o(busy), .port_o(fl_port), .word_o(fl_word)
  );

  for (genvar p = 0; p < NP; p++) begin : g_port
    rx_ev_t rx_ev;
    tx_ev_t tx_ev;
    assign rx_ev.vld  = rx_vld_i[p];
    assign rx_ev.kind = rx_kind_i[p*2 +: 2];
    assign rx_ev.err  = rx_err_i[p*5 +: 5];
    assign rx_ev.len  = 16'(rx_len_i[p*LEN_W +: LEN_W]);
    assign tx_ev.vld  = tx_vld_i[p];
    assign tx_ev.kind = tx_kind_i[p*2 +: 2];
    assign tx_ev.err  = tx_err_i[p*9 +: 9];
    assign tx_ev.len  = 16'(tx_len_i[p*LEN_W +: LEN_W]);

    stats_port #(.NW(NW)) u_port (
      .clk_i, .rst_ni, .en_i(en_q), .rx_i(rx_ev), .tx_i(tx_ev),
      .clr_i(busy && int'(fl_port) == p), .clr_word_i(fl_word),
      .rd_word_i(rd_word[WW-1:0]), .rd_data_o(port_rd[p])
    );
  end

  always_comb begin
    rd_val = '0;
    if (rd_addr_i == CTRL_ADDR)    rd_val = {31'd0, busy};
    else if (rd_addr_i == EN_ADDR) rd_val = {31'd0, en_q};
    else if (rd_addr_i[15:12] == 4'h1 && rd_addr_i[1:0] == 2'b00 &&
             int'(rd_port) < NP && int'(rd_word) < NW)
      rd_val = port_rd[rd_port[PW-1:0]];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_q <= '0;
    else if (rd_en_i) rd_data_q <= rd_val;
  end

  assign rd_data_o = rd_data_q;
endmodule

// File: rtl/stats_chk.sv
module stats_chk #(
  parameter int          NP        = 2,
  parameter int          NW        = 44,
  parameter logic [15:0] CTRL_ADDR = 16'h0030,
  parameter logic [15:0] EN_ADDR   = 16'h0034
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [15:0] wr_addr_i,
  input logic [31:0] wr_data_i,
  input logic        rd_en_i,
  input logic [15:0] rd_addr_i,
  input logic [31:0] rd_data_o,
  input logic        busy_i,
  input logic        en_i
);
  localparam int TOTAL = NP * NW;
  logic [15:0] busy_cnt;
  logic        ctl_wr, unmapped;

  assign ctl_wr   = wr_en_i && wr_addr_i == CTRL_ADDR;
  assign unmapped = rd_addr_i[15:12] != 4'h1 && rd_addr_i != CTRL_ADDR && rd_addr_i != EN_ADDR;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt <= '0;
    else if (busy_i) busy_cnt <= busy_cnt + 16'd1;
    else             busy_cnt <= '0;
  end

  // R10
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> busy_cnt == 16'(TOTAL));

  // R10
  flush_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr && wr_data_i[1:0] == 2'b11 && !busy_i) |=> busy_i);

  // R10
  flush_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr && wr_data_i[1:0] != 2'b11 && !busy_i) |=> !busy_i);

  // R9
  en_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == EN_ADDR) |=> en_i == $past(wr_data_i[0]));

  // R2
  unmapped_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && unmapped) |=> rd_data_o == 32'd0);

  // R2
  ctrl_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_addr_i == CTRL_ADDR) |=> rd_data_o == {31'd0, $past(busy_i)});
endmodule

bind stats_top stats_chk #(.NP(NP), .NW(NW), .CTRL_ADDR(CTRL_ADDR), .EN_ADDR(EN_ADDR)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
  .rd_data_o(rd_data_o), .busy_i(busy), .en_i(en_q)
);

// File: tb/sim_stats_top.sv
`timescale 1ns/1ps
module sim_stats_top;
  localparam int NP = 2, LW = 14, NW = 44, TOTAL = NP * NW;
  localparam logic [15:0] CTRL = 16'h0030, ENR = 16'h0034;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [NP-1:0] rx_vld = '0, tx_vld = '0;
  logic [NP*LW-1:0] rx_len = '0, tx_len = '0;
  logic [NP*2-1:0] rx_kind = '0, tx_kind = '0;
  logic [NP*5-1:0] rx_err = '0;
  logic [NP*9-1:0] tx_err = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;

  int errors = 0, checks = 0;
  logic en_m = 1'b0;
  logic [31:0] exp_q [NP][NW];

  always #2.5 clk = ~clk;

  stats_top #(.NP(NP), .LEN_W(LW)) u0 (
    .clk_i(clk), .rst_ni, .rx_vld_i(rx_vld), .rx_len_i(rx_len), .rx_kind_i(rx_kind),
    .rx_err_i(rx_err), .tx_vld_i(tx_vld), .tx_len_i(tx_len), .tx_kind_i(tx_kind),
    .tx_err_i(tx_err), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  function automatic int bucket(input int l);
    if (l <= 64) return 0;
    if (l <= 127) return 1;
    if (l <= 255) return 2;
    if (l <= 511) return 3;
    if (l <= 1023) return 4;
    if (l <= 1518) return 5;
    return 6;
  endfunction

  function automatic string req_of(input int w);
    if (w <= 2 || (w >= 21 && w <= 23)) return "R3";
    if ((w >= 7 && w <= 13) || (w >= 25 && w <= 31)) return "R4";
    if (w == 3 || w == 5 || w == 6) return "R5";
    if (w == 4 || w == 14 || w == 19 || w == 20) return "R6";
    if ((w >= 15 && w <= 18) || w == 33 || w == 34) return "R7";
    if (w >= 42) return "R2";
    return "R8";
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic add64(input int p, input int w, input int l);
    logic [63:0] s;
    s = {exp_q[p][w+1], exp_q[p][w]} + 64'(l);
    exp_q[p][w] = s[31:0];
    exp_q[p][w+1] = s[63:32];
  endtask

  task automatic model_rx(input int p, input int l, input logic [1:0] k, input logic [4:0] e);
    if (!en_m) return;
    if (k == 2'd1) exp_q[p][0]++;
    if (k == 2'd2) exp_q[p][2]++;
    if (k == 2'd3) exp_q[p][1]++;
    if (l >= 64) begin
      exp_q[p][7 + bucket(l)]++;
      if (e[0]) exp_q[p][3]++;
    end else if (e[0]) exp_q[p][6]++;
    else exp_q[p][5]++;
    if (e[1]) exp_q[p][4]++;
    if (e[2]) exp_q[p][14]++;
    if (e[3]) exp_q[p][19]++;
    if (e[4]) exp_q[p][20]++;
    if (l >= 64 && e[3:0] == 4'd0) add64(p, 15, l);
    else add64(p, 17, l);
  endtask

  task automatic model_tx(input int p, input int l, input logic [1:0] k, input logic [8:0] e);
    int map [9] = '{24, 32, 35, 36, 37, 38, 39, 40, 41};
    if (!en_m) return;
    if (k == 2'd1) exp_q[p][21]++;
    if (k == 2'd2) exp_q[p][23]++;
    if (k == 2'd3) exp_q[p][22]++;
    if (l >= 64) exp_q[p][25 + bucket(l)]++;
    for (int b = 0; b < 9; b++) if (e[b]) exp_q[p][map[b]]++;
    add64(p, 33, l);
  endtask

  task automatic set_rx(input int p, input int l, input logic [1:0] k, input logic [4:0] e);
    rx_vld[p] = 1'b1; rx_len[p*LW +: LW] = LW'(l); rx_kind[p*2 +: 2] = k; rx_err[p*5 +: 5] = e;
    model_rx(p, l, k, e);
  endtask

  task automatic set_tx(input int p, input int l, input logic [1:0] k, input logic [8:0] e);
    tx_vld[p] = 1'b1; tx_len[p*LW +: LW] = LW'(l); tx_kind[p*2 +: 2] = k; tx_err[p*9 +: 9] = e;
    model_tx(p, l, k, e);
  endtask

  task automatic idle_ev();
    rx_vld = '0; tx_vld = '0; rx_err = '0; tx_err = '0; rx_kind = '0; tx_kind = '0;
  endtask

  task automatic rx_one(input int p, input int l, input logic [1:0] k, input logic [4:0] e);
    @(negedge clk); set_rx(p, l, k, e);
    @(negedge clk); idle_ev();
  endtask

  task automatic tx_one(input int p, input int l, input logic [1:0] k, input logic [8:0] e);
    @(negedge clk); set_tx(p, l, k, e);
    @(negedge clk); idle_ev();
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); d = rd_data; rd_en = 1'b0;
  endtask

  task automatic dump(input string tag);
    logic [31:0] d;
    for (int p = 0; p < NP; p++)
      for (int w = 0; w < NW; w++) begin
        rd(16'h1000 + 16'(p * 256 + w * 4), d);
        check(tag == "" ? req_of(w) : tag, $sformatf("port %0d word %0d", p, w), d, exp_q[p][w]);
      end
  endtask

  task automatic clear_model();
    for (int p = 0; p < NP; p++) for (int w = 0; w < NW; w++) exp_q[p][w] = '0;
  endtask

  task automatic random_traffic(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); idle_ev();
      for (int p = 0; p < NP; p++) begin
        if ($urandom_range(0, 2) != 0)
          set_rx(p, $urandom_range(1, 2000), 2'($urandom_range(0, 3)),
                 ($urandom_range(0, 3) == 0) ? 5'($urandom_range(0, 31)) : 5'd0);
        if ($urandom_range(0, 2) != 0)
          set_tx(p, $urandom_range(1, 2000), 2'($urandom_range(0, 3)),
                 ($urandom_range(0, 3) == 0) ? 9'($urandom_range(0, 511)) : 9'd0);
      end
    end
    @(negedge clk); idle_ev();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] d;
    int ones, tgt, rl [13];
    void'($urandom(32'd1234));
    clear_model();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    rd(CTRL, d); check("R1", "ctrl after reset", d, 32'd0);
    rd(ENR, d);  check("R1", "enable after reset", d, 32'd0);
    dump("R1");

    // R9 disabled: strobes ignored
    random_traffic(50);
    dump("R9");
    wr(ENR, 32'd1); en_m = 1'b1;
    rd(ENR, d); check("R9", "enable readback", d, 32'd1);

    // R4 bucket edges, R3 classes, R5 short frames, R6/R8 flags, R7 bytes
    rl = '{63, 64, 65, 127, 128, 255, 256, 511, 512, 1023, 1024, 1518, 1519};
    foreach (rl[i]) begin
      rx_one(0, rl[i], 2'(i % 4), 5'd0);
      tx_one(1, rl[i], 2'((i + 1) % 4), 9'd0);
    end
    rx_one(0, 40, 2'd0, 5'b00001);
    rx_one(1, 20, 2'd1, 5'b00000);
    rx_one(1, 100, 2'd2, 5'b00001);
    rx_one(1, 300, 2'd0, 5'b11110);
    for (int b = 0; b < 9; b++) tx_one(0, 70 + b, 2'd3, 9'(1 << b));
    tx_one(0, 30, 2'd0, 9'd0);
    dump("");

    random_traffic(1500);
    dump("");

    // R2 unmapped, out-of-range port, reserved, misaligned
    rd(16'h2000, d); check("R2", "unmapped 0x2000", d, 32'd0);
    rd(16'h1000 + 16'(NP * 256), d); check("R2", "port beyond NP", d, 32'd0);
    rd(16'h10B0, d); check("R2", "word 44", d, 32'd0);
    rd(16'h1002, d); check("R2", "misaligned", d, 32'd0);
    rd(16'h0038, d); check("R2", "unmapped 0x0038", d, 32'd0);

    // R10 flush bit alone does nothing
    wr(CTRL, 32'd2);
    rd(CTRL, d); check("R10", "flush-only busy", d, 32'd0);
    dump("R10");

    // R10/R11/R12 full flush with restart attempt and conflicting strobe
    tgt = (NP - 1) * NW + 41 + 1;
    ones = 0;
    @(negedge clk); wr_en = 1'b1; wr_addr = CTRL; wr_data = 32'd3; rd_en = 1'b1; rd_addr = CTRL;
    for (int k = 0; k < 3 * TOTAL; k++) begin
      @(negedge clk);
      wr_en = 1'b0; idle_ev();
      if (k == 10) begin wr_en = 1'b1; wr_addr = CTRL; wr_data = 32'd3; end
      if (k + 1 == tgt) begin
        tx_vld[NP-1] = 1'b1; tx_len[(NP-1)*LW +: LW] = LW'(64);
        tx_kind[(NP-1)*2 +: 2] = 2'd1; tx_err[(NP-1)*9 +: 9] = 9'h100;
      end
      if (rd_data[0]) ones++;
      else if (k > 0) break;
    end
    wr_en = 1'b0; rd_en = 1'b0; idle_ev();
    check("R12", "busy cycles with restart attempt", 32'(ones), 32'(TOTAL));
    clear_model();
    exp_q[NP-1][21] = 32'd1;
    exp_q[NP-1][25] = 32'd1;
    exp_q[NP-1][33] = 32'd64;
    dump("R11");
    rd(CTRL, d); check("R10", "busy after flush", d, 32'd0);

    random_traffic(300);
    dump("");
    summary();
  end
endmodule